// File: doc/BRIEF.md
# PLL Factor Change Sequencer

This block moves a PLL from its present multiplier and divider settings to a newly requested set without letting the output clock rise above the higher of the old and new frequencies while the oscillator settles. Divider changes reach the output at once. Multiplier changes make the oscillator ramp slowly. The sequencer therefore raises dividers before it touches the multipliers. It lowers dividers only after the PLL reports lock.

A request carries two multipliers (N, K), two dividers (pre-divider P, post-divider M) and two hints about a dependent bus clock: the new frequency is above the bus threshold, or it is below it. The sequencer drives a PLL configuration register through read-modify-write updates. It waits fixed cycle counts after divider raises and after the multiplier write, then polls the lock bit. It raises the bus-clock divider before the PLL change and lowers it after the change. `busy` covers the whole sequence. `done` pulses once at the end.

Top module: `pll_retune_seq`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high, and `busy` is high in the next cycle. Requests offered while busy have no effect on the register or on the bus divider.
- R2: If the requested P is larger than the P field now in the register (bits [17:16]), P alone is written first. The next register write comes no sooner than LONG_DLY cycles later: exactly LONG_DLY+1 cycles later when M is also raised.
- R3: If the requested M is larger than the M field (bits [1:0]), M alone is written after any P raise, followed by another LONG_DLY wait.
- R4: N (bits [12:8]) and K (bits [5:4]) are written together in one register write, and no further write happens within SHORT_DLY cycles.
- R5: After the N/K write, no further register write is made and `done` does not rise until the lock bit (bit 28) reads 1.
- R6: A requested P or M that is smaller than the current field is written only after lock, P before M.
- R7: Every write copies all register bits other than the field being changed from the value read in the same cycle.
- R8: `bus_div` resets to BUS_HI. When the fast hint is set and `bus_div` is below BUS_HI, it is raised to BUS_HI before the first register write. When the slow hint is set and `bus_div` is above BUS_LO, it is lowered to BUS_LO only after the last register write. It holds one value across all register writes of a sequence.
- R9: `done` is high for exactly one cycle, at the end of a sequence, in the same cycle that `busy` falls.
- R10: A request equal to the current fields makes exactly one register write (N/K), waits for lock, and finishes.
- R11: With multiplier (n+1)(k+1) ramping one step at a time, and output = oscillator / ((p+1)(m+1)), the output never exceeds the larger of the old and new frequencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_n | input | N_W | Requested N field |
| req_k | input | K_W | Requested K field |
| req_m | input | M_W | Requested M field |
| req_p | input | P_W | Requested P field |
| req_fast | input | 1 | New frequency above bus threshold |
| req_slow | input | 1 | New frequency below bus threshold |
| cfg_rdata | input | CFG_W | PLL configuration register readback, including lock bit |
| cfg_wr | output | 1 | Register write strobe |
| cfg_wdata | output | CFG_W | Register write value |
| bus_div | output | BUS_W | Dependent bus-clock divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The end of one sequence and the start of the next can fall in the same cycle. `done` is high and the sequencer is idle, so a request offered then is taken at once. The bench makes this happen by presenting the next request in the very cycle it sees `done`. It then checks that `busy` is high and `done` low in the following cycle, and that the second sequence ends with the right fields. Lock arriving in the same cycle the lock poll starts is also covered by requests whose multiplier product does not change.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int CFG_W     = 32,
  parameter int N_LSB     = 8,
  parameter int N_W       = 5,
  parameter int K_LSB     = 4,
  parameter int K_W       = 2,
  parameter int M_LSB     = 0,
  parameter int M_W       = 2,
  parameter int P_LSB     = 16,
  parameter int P_W       = 2,
  parameter int LOCK_BIT  = 28,
  parameter int BUS_W     = 2,
  parameter int BUS_HI    = 2,
  parameter int BUS_LO    = 1,
  parameter int LONG_DLY  = 2000,
  parameter int SHORT_DLY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [N_W-1:0]   req_n,
  input  logic [K_W-1:0]   req_k,
  input  logic [M_W-1:0]   req_m,
  input  logic [P_W-1:0]   req_p,
  input  logic             req_fast,
  input  logic             req_slow,
  input  logic [CFG_W-1:0] cfg_rdata,
  output logic             cfg_wr,
  output logic [CFG_W-1:0] cfg_wdata,
  output logic [BUS_W-1:0] bus_div,
  output logic             busy,
  output logic             done
);
  localparam int MAXD  = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam logic [CFG_W-1:0] N_MASK = {{(CFG_W-N_W){1'b0}}, {N_W{1'b1}}} << N_LSB;
  localparam logic [CFG_W-1:0] K_MASK = {{(CFG_W-K_W){1'b0}}, {K_W{1'b1}}} << K_LSB;
  localparam logic [CFG_W-1:0] M_MASK = {{(CFG_W-M_W){1'b0}}, {M_W{1'b1}}} << M_LSB;
  localparam logic [CFG_W-1:0] P_MASK = {{(CFG_W-P_W){1'b0}}, {P_W{1'b1}}} << P_LSB;

  typedef enum logic [3:0] {
    S_IDLE, S_BUS_UP, S_P_UP, S_WAIT_P, S_M_UP, S_WAIT_M,
    S_NK, S_WAIT_NK, S_LOCK, S_P_DN, S_M_DN, S_BUS_DN
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [N_W-1:0]    n_q;
  logic [K_W-1:0]    k_q;
  logic [M_W-1:0]    m_q;
  logic [P_W-1:0]    p_q;
  logic              fast_q, slow_q;

  wire [P_W-1:0] cur_p  = cfg_rdata[P_LSB +: P_W];
  wire [M_W-1:0] cur_m  = cfg_rdata[M_LSB +: M_W];
  wire           locked = cfg_rdata[LOCK_BIT];

  wire [CFG_W-1:0] with_p  = (cfg_rdata & ~P_MASK) | (CFG_W'(p_q) << P_LSB);
  wire [CFG_W-1:0] with_m  = (cfg_rdata & ~M_MASK) | (CFG_W'(m_q) << M_LSB);
  wire [CFG_W-1:0] with_nk = (cfg_rdata & ~(N_MASK | K_MASK))
                           | (CFG_W'(n_q) << N_LSB) | (CFG_W'(k_q) << K_LSB);

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);

  always_comb begin
    cfg_wr    = 1'b0;
    cfg_wdata = cfg_rdata;
    case (state)
      S_P_UP: if (p_q > cur_p) begin cfg_wr = 1'b1; cfg_wdata = with_p; end
      S_M_UP: if (m_q > cur_m) begin cfg_wr = 1'b1; cfg_wdata = with_m; end
      S_NK:   begin cfg_wr = 1'b1; cfg_wdata = with_nk; end
      S_P_DN: if (p_q < cur_p) begin cfg_wr = 1'b1; cfg_wdata = with_p; end
      S_M_DN: if (m_q < cur_m) begin cfg_wr = 1'b1; cfg_wdata = with_m; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      n_q     <= '0;
      k_q     <= '0;
      m_q     <= '0;
      p_q     <= '0;
      fast_q  <= 1'b0;
      slow_q  <= 1'b0;
      bus_div <= BUS_W'(BUS_HI);
      done    <= 1'b0;
    end else begin
      done <= (state == S_BUS_DN);
      case (state)
        S_IDLE: if (req_valid) begin
          n_q    <= req_n;
          k_q    <= req_k;
          m_q    <= req_m;
          p_q    <= req_p;
          fast_q <= req_fast;
          slow_q <= req_slow;
          state  <= S_BUS_UP;
        end
        S_BUS_UP: begin
          if (fast_q && bus_div < BUS_W'(BUS_HI)) bus_div <= BUS_W'(BUS_HI);
          state <= S_P_UP;
        end
        S_P_UP: begin
          cnt   <= CNT_W'(LONG_DLY - 1);
          state <= (p_q > cur_p) ? S_WAIT_P : S_M_UP;
        end
        S_WAIT_P: begin
          cnt <= cnt - 1'b1;
          if (cnt == '0) state <= S_M_UP;
        end
        S_M_UP: begin
          cnt   <= CNT_W'(LONG_DLY - 1);
          state <= (m_q > cur_m) ? S_WAIT_M : S_NK;
        end
        S_WAIT_M: begin
          cnt <= cnt - 1'b1;
          if (cnt == '0) state <= S_NK;
        end
        S_NK: begin
          cnt   <= CNT_W'(SHORT_DLY - 1);
          state <= S_WAIT_NK;
        end
        S_WAIT_NK: begin
          cnt <= cnt - 1'b1;
          if (cnt == '0) state <= S_LOCK;
        end
        S_LOCK: if (locked) state <= S_P_DN;
        S_P_DN: state <= S_M_DN;
        S_M_DN: state <= S_BUS_DN;
        S_BUS_DN: begin
          if (slow_q && bus_div > BUS_W'(BUS_LO)) bus_div <= BUS_W'(BUS_LO);
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module pll_retune_seq_chk #(
  parameter int CFG_W     = 32,
  parameter int M_LSB     = 0,
  parameter int M_W       = 2,
  parameter int P_LSB     = 16,
  parameter int P_W       = 2,
  parameter int N_LSB     = 8,
  parameter int N_W       = 5,
  parameter int K_LSB     = 4,
  parameter int K_W       = 2,
  parameter int LOCK_BIT  = 28,
  parameter int BUS_W     = 2,
  parameter int LONG_DLY  = 2000,
  parameter int SHORT_DLY = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [BUS_W-1:0] bus_div,
  input logic             busy,
  input logic             done
);
  localparam int GAP_W = $clog2(LONG_DLY + SHORT_DLY + 2) + 1;
  localparam logic [CFG_W-1:0] FIELDS =
      ({{(CFG_W-N_W){1'b0}}, {N_W{1'b1}}} << N_LSB) |
      ({{(CFG_W-K_W){1'b0}}, {K_W{1'b1}}} << K_LSB) |
      ({{(CFG_W-M_W){1'b0}}, {M_W{1'b1}}} << M_LSB) |
      ({{(CFG_W-P_W){1'b0}}, {P_W{1'b1}}} << P_LSB);

  wire p_up = cfg_wdata[P_LSB +: P_W] > cfg_rdata[P_LSB +: P_W];
  wire m_up = cfg_wdata[M_LSB +: M_W] > cfg_rdata[M_LSB +: M_W];
  wire p_dn = cfg_wdata[P_LSB +: P_W] < cfg_rdata[P_LSB +: P_W];
  wire m_dn = cfg_wdata[M_LSB +: M_W] < cfg_rdata[M_LSB +: M_W];
  wire accept = req_valid && req_ready;

  logic [GAP_W-1:0] gap_q;
  logic up_q, last_nk_q, nk_q, lk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; up_q <= 1'b0; last_nk_q <= 1'b0; nk_q <= 1'b0; lk_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        gap_q     <= '0;
        up_q      <= p_up || m_up;
        last_nk_q <= !(p_up || m_up || p_dn || m_dn);
      end else if (gap_q != {GAP_W{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
      if (accept) begin
        nk_q <= 1'b0;
        lk_q <= 1'b0;
      end else begin
        if (cfg_wr && !(p_up || m_up || p_dn || m_dn)) nk_q <= 1'b1;
        if (nk_q && !cfg_wr && cfg_rdata[LOCK_BIT]) lk_q <= 1'b1;
      end
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_long_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && up_q) |-> (gap_q >= GAP_W'(LONG_DLY)));
  assert_short_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && last_nk_q) |-> (gap_q >= GAP_W'(SHORT_DLY)));
  assert_lower_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (p_dn || m_dn)) |-> lk_q);
  assert_rmw_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (((cfg_wdata ^ cfg_rdata) & ~FIELDS) == '0));
  assert_bus_lower_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_div < $past(bus_div)) |-> lk_q);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_write_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> busy);
endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .CFG_W(CFG_W), .M_LSB(M_LSB), .M_W(M_W), .P_LSB(P_LSB), .P_W(P_W),
  .N_LSB(N_LSB), .N_W(N_W), .K_LSB(K_LSB), .K_W(K_W), .LOCK_BIT(LOCK_BIT),
  .BUS_W(BUS_W), .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_rdata(cfg_rdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .bus_div(bus_div), .busy(busy), .done(done)
);

// File: tb/test_pll_retune_seq.sv
module test_pll_retune_seq;
  localparam int LONG  = 40;
  localparam int SHORT = 6;
  localparam int RAMP  = 2;
  localparam logic [31:0] SPARE = 32'h0340_0088;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_fast = 1'b0, req_slow = 1'b0;
  logic [4:0] req_n = '0;
  logic [1:0] req_k = '0, req_m = '0, req_p = '0;
  logic [31:0] cfg_rdata, cfg_wdata;
  logic cfg_wr, busy, done;
  logic [1:0] bus_div;

  always #2 clk = ~clk;

  pll_retune_seq #(.LONG_DLY(LONG), .SHORT_DLY(SHORT)) i_pll_retune_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_n(req_n), .req_k(req_k), .req_m(req_m), .req_p(req_p),
    .req_fast(req_fast), .req_slow(req_slow), .cfg_rdata(cfg_rdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .bus_div(bus_div),
    .busy(busy), .done(done));

  // behavioural PLL: fields N[12:8] K[5:4] M[1:0] P[17:16], lock bit 28
  logic [31:0] reg_q;
  int vco, rcnt;
  function automatic int tgt(logic [31:0] r);
    return (int'(r[12:8]) + 1) * (int'(r[5:4]) + 1);
  endfunction
  function automatic real outf(int v, logic [31:0] r);
    return real'(v) / real'((int'(r[17:16]) + 1) * (int'(r[1:0]) + 1));
  endfunction
  wire lock = (vco == tgt(reg_q));
  assign cfg_rdata = (reg_q & ~(32'h1 << 28)) | (32'(lock) << 28);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= SPARE | (32'd10 << 8) | (32'd1 << 4);
      vco   <= 22;
      rcnt  <= 0;
    end else begin
      if (cfg_wr) reg_q <= cfg_wdata & ~(32'h1 << 28);
      rcnt <= (rcnt == RAMP - 1) ? 0 : rcnt + 1;
      if (rcnt == RAMP - 1) begin
        if (vco < tgt(reg_q)) vco <= vco + 1;
        else if (vco > tgt(reg_q)) vco <= vco - 1;
      end
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] n, input logic [1:0] k, m, p,
                     input bit fast, slow, interfere);
    int op, om, nw, pu, mu, pd, md, cyc, widx, bus_mid, bus_end;
    int wcyc[5];
    logic [31:0] wd[5];
    bit over, bus_bad, lock_bad;
    real fo, fn, fmax;
    logic [31:0] nreg;
    while (!req_ready) @(negedge clk);
    op = int'(reg_q[17:16]); om = int'(reg_q[1:0]);
    pu = int'(p > op); mu = int'(m > om); pd = int'(p < op); md = int'(m < om);
    nw = pu + mu + 1 + pd + md;
    bus_mid = (fast && bus_div < 2) ? 2 : int'(bus_div);
    bus_end = (slow && bus_mid > 1) ? 1 : bus_mid;
    nreg = (reg_q & ~32'h0003_1F33) | (32'(n) << 8) | (32'(k) << 4) | 32'(m) | (32'(p) << 16);
    fo = outf(tgt(reg_q), reg_q);
    fn = outf(tgt(nreg), nreg);
    fmax = (fo > fn) ? fo : fn;
    req_n = n; req_k = k; req_m = m; req_p = p; req_fast = fast; req_slow = slow;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !done, "R9 busy after accept, done dropped", int'({busy, done}), 2);
    widx = 0; cyc = 0; over = 0; bus_bad = 0; lock_bad = 0;
    while (!done && cyc < 5000) begin
      if (interfere && cyc >= 3 && cyc < 15) begin
        req_valid = 1'b1; req_n = ~n; req_k = ~k; req_m = ~m; req_p = ~p;
        req_slow = 1'b1; req_fast = 1'b0;
      end else req_valid = 1'b0;
      if (cfg_wr) begin
        if (widx < 5) begin wcyc[widx] = cyc; wd[widx] = cfg_wdata; end
        if (int'(bus_div) != bus_mid) bus_bad = 1;
        if (widx > pu + mu && !lock) lock_bad = 1;
        widx++;
      end
      if (outf(vco, reg_q) > fmax + 1.0e-9) over = 1;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(done, "R9 sequence ends with done", int'(done), 1);
    chk(widx == nw, "R2 R3 R6 R10 number of register writes", widx, nw);
    chk(reg_q == nreg, interfere ? "R1 busy request ignored, final register" :
        "R7 final register", int'(reg_q), int'(nreg));
    chk(lock, "R5 done only after lock", int'(lock), 1);
    chk(!lock_bad, "R5 R6 no divider lowering before lock", int'(lock_bad), 0);
    chk(!bus_bad, "R8 bus divider during writes", int'(bus_bad), 0);
    chk(int'(bus_div) == bus_end, "R8 bus divider at end", int'(bus_div), bus_end);
    chk(!over, "R11 output never above max(old,new)", int'(over), 0);
    if (widx == nw) begin
      wd[pu + mu] = wd[pu + mu];
      chk(wd[pu + mu][12:8] == n && wd[pu + mu][5:4] == k, "R4 N and K in one write",
          int'(wd[pu + mu][12:4]), int'({n, 2'b00, k}));
      if (pu == 1 && mu == 1)
        chk(wcyc[1] - wcyc[0] == LONG + 1, "R2 wait after P raise", wcyc[1] - wcyc[0], LONG + 1);
      if (pu == 1)
        chk(wd[0][17:16] == p && wd[0][12:8] == reg_q[12:8] - (reg_q[12:8] - wd[0][12:8]),
            "R2 P written first", int'(wd[0][17:16]), int'(p));
      if (mu == 1)
        chk(wd[pu][1:0] == m, "R3 M raise write", int'(wd[pu][1:0]), int'(m));
      if (pd + md > 0)
        chk(wcyc[pu + mu + 1] - wcyc[pu + mu] > SHORT, "R4 R5 gap after N/K write",
            wcyc[pu + mu + 1] - wcyc[pu + mu], SHORT + 1);
      if (pd == 1 && md == 1)
        chk(wd[nw - 2][17:16] == p && wd[nw - 1][1:0] == m, "R6 P lowered before M",
            int'(wd[nw - 2][17:16]), int'(p));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !done && !cfg_wr, "R1 R9 reset idle",
        int'({req_ready, busy, done, cfg_wr}), 8);
    chk(bus_div == 2'd2, "R8 reset bus divider", int'(bus_div), 2);
    rst_n = 1'b1;
    @(negedge clk);
    run(5'd10, 2'd1, 2'd0, 2'd0, 0, 0, 0);            // R10 equal factors
    run(5'd31, 2'd3, 2'd3, 2'd3, 1, 0, 0);            // raise all
    run(5'd3, 2'd0, 2'd0, 2'd0, 0, 1, 0);             // lower dividers after lock
    run(5'd20, 2'd2, 2'd2, 2'd1, 1, 0, 1);            // R1 interference
    run(5'd20, 2'd2, 2'd2, 2'd1, 0, 1, 0);            // R10 again
    run(5'd1, 2'd3, 2'd0, 2'd3, 0, 0, 0);             // back-to-back with previous done
    for (int i = 0; i < 40; i++)
      run(5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)));
    @(negedge clk);
    chk(!done && !busy, "R9 done single cycle", int'({done, busy}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule